// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block sits in the execute stage of a small packet-filter style processor. It looks at one jump-class instruction together with the two register operands and the current program counter. It then decides whether control leaves the sequential path and produces the address of the next instruction slot. The program counter counts 8-byte instruction slots, so a step of one means "the following instruction".

Two compare classes share one opcode layout. Class 0x05 compares the full 64-bit operands. Class 0x06 compares only the low 32 bits of each operand. Opcode bits [7:4] select the condition and bit 3 selects the second operand. Call and exit encodings do not change control flow here, apart from a local call. Instead they raise request flags for the surrounding pipeline, which owns the return stack and the helper dispatch. Encodings that cannot be executed raise an illegal flag.

All results pass through one register stage and appear one clock after the inputs are presented.

Top module: `bnpc_unit`

## Requirements
- R1: While reset is held and after it is released with no clock edge yet taken, all flags are low and the next PC output is zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. They do not change between edges.
- R3: Opcode class bits [2:0] = 5 compare all 64 operand bits. Class 6 compares only bits [31:0], so the upper halves of both operands have no effect on the result.
- R4: Opcode bit 3 = 1 uses the source register value as the second operand. Bit 3 = 0 uses the 32-bit immediate, sign-extended to the compare width.
- R5: Code 0x1 is taken on equality, code 0x5 on inequality, and code 0x4 when the bitwise AND of the operands is nonzero.
- R6: Unsigned codes: 0x2 greater, 0x3 greater-or-equal, 0xa less, 0xb less-or-equal.
- R7: Signed (two's complement) codes: 0x6 greater, 0x7 greater-or-equal, 0xc less, 0xd less-or-equal.
- R8: For a taken conditional branch, next PC = PC + 1 + sign-extended 16-bit offset. For any untaken instruction, next PC = PC + 1. Both wrap modulo 2^PC_W.
- R9: Code 0x0 is always taken. Its displacement is the 16-bit offset in class 5 and the signed 32-bit immediate in class 6.
- R10: Code 0x8 raises the call flag. A source-field value of 1 is a local call: it is taken, uses the immediate as displacement, and raises the local flag. Source-field values 0 and 2 are helper calls: not taken, next PC = PC + 1. Any other source-field value is illegal.
- R11: Code 0x9 in class 5 raises the exit flag and is not taken. In class 6 it is illegal.
- R12: Codes 0xe and 0xf are illegal. An illegal instruction is never taken, raises neither call nor exit, and gives next PC = PC + 1.
- R13: Any class other than 5 or 6 raises no flag, is not taken, and gives next PC = PC + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| opcode_i | input | 8 | Instruction opcode byte |
| src_field_i | input | 4 | Instruction source-register field (call kind) |
| offset_i | input | 16 | Signed 16-bit offset field |
| imm_i | input | 32 | Signed 32-bit immediate field |
| dst_val_i | input | XLEN | Destination register value |
| src_val_i | input | XLEN | Source register value |
| pc_i | input | PC_W | Current PC in instruction slots |
| taken_o | output | 1 | Control leaves the sequential path |
| next_pc_o | output | PC_W | Next instruction slot |
| call_o | output | 1 | Call request |
| call_local_o | output | 1 | Call is program-local |
| exit_o | output | 1 | Exit request |
| illegal_o | output | 1 | Unexecutable encoding |

## Verification
The hardest cases to reach are the ones where the two compare widths disagree. These are operand pairs whose low halves order one way while their full 64-bit values order the other way, and immediates whose sign extension flips a result.

The stimulus sweeps every condition code in both classes with both operand sources. It draws from a value set built for these boundaries: sign-bit patterns at bit 31 and bit 63, low-half equality with unequal upper halves, and all-ones. Every combination is compared with an arithmetic model, and the PC is placed at the wrap point for the displacement checks.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    localparam logic [2:0] CLS_J64 = 3'd5;
    localparam logic [2:0] CLS_J32 = 3'd6;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'h0, CC_EQ  = 4'h1, CC_UGT = 4'h2, CC_UGE = 4'h3,
        CC_TEST   = 4'h4, CC_NE  = 4'h5, CC_SGT = 4'h6, CC_SGE = 4'h7,
        CC_CALL   = 4'h8, CC_EXIT = 4'h9, CC_ULT = 4'ha, CC_ULE = 4'hb,
        CC_SLT    = 4'hc, CC_SLE = 4'hd, CC_RSV_E = 4'he, CC_RSV_F = 4'hf
    } cond_e;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_OFF  = 2'd1,
        DISP_IMM  = 2'd2
    } disp_e;

    typedef struct packed {
        logic  is_cond;
        logic  uncond;
        logic  call;
        logic  call_local;
        logic  exit;
        logic  illegal;
        disp_e disp_sel;
        cond_e code;
        logic  wide;
        logic  use_reg;
    } dec_t;

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
    import bnpc_pkg::*;
(
    input  logic [7:0] opcode_i,
    input  logic [3:0] src_field_i,
    output dec_t       dec_o
);

    logic [2:0] cls;
    cond_e      code;

    assign cls  = opcode_i[2:0];
    assign code = cond_e'(opcode_i[7:4]);

    always_comb begin
        dec_o          = '0;
        dec_o.code     = code;
        dec_o.wide     = (cls == CLS_J64);
        dec_o.use_reg  = opcode_i[3];
        dec_o.disp_sel = DISP_NONE;
        if (cls == CLS_J64 || cls == CLS_J32) begin
            case (code)
                CC_ALWAYS: begin
                    dec_o.uncond   = 1'b1;
                    dec_o.disp_sel = (cls == CLS_J64) ? DISP_OFF : DISP_IMM;
                end
                CC_CALL: begin
                    if (src_field_i == 4'd1) begin
                        dec_o.call       = 1'b1;
                        dec_o.call_local = 1'b1;
                        dec_o.uncond     = 1'b1;
                        dec_o.disp_sel   = DISP_IMM;
                    end else if (src_field_i == 4'd0 || src_field_i == 4'd2) begin
                        dec_o.call = 1'b1;
                    end else begin
                        dec_o.illegal = 1'b1;
                    end
                end
                CC_EXIT: begin
                    if (cls == CLS_J64) dec_o.exit    = 1'b1;
                    else                dec_o.illegal = 1'b1;
                end
                CC_RSV_E, CC_RSV_F: begin
                    dec_o.illegal = 1'b1;
                end
                default: begin
                    dec_o.is_cond  = 1'b1;
                    dec_o.disp_sel = DISP_OFF;
                end
            endcase
        end
    end

endmodule

// File: rtl/bnpc_compare.sv
module bnpc_compare
    import bnpc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  cond_e        code_i,
    output logic         hit_o
);

    logic eq, ult, slt;

    assign eq  = (lhs_i == rhs_i);
    assign ult = (lhs_i < rhs_i);
    assign slt = ($signed(lhs_i) < $signed(rhs_i));

    always_comb begin
        case (code_i)
            CC_EQ:   hit_o = eq;
            CC_NE:   hit_o = !eq;
            CC_TEST: hit_o = |(lhs_i & rhs_i);
            CC_UGT:  hit_o = !ult && !eq;
            CC_UGE:  hit_o = !ult;
            CC_ULT:  hit_o = ult;
            CC_ULE:  hit_o = ult || eq;
            CC_SGT:  hit_o = !slt && !eq;
            CC_SGE:  hit_o = !slt;
            CC_SLT:  hit_o = slt;
            CC_SLE:  hit_o = slt || eq;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
    import bnpc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc_i,
    input  disp_e           disp_sel_i,
    input  logic [15:0]     offset_i,
    input  logic [31:0]     imm_i,
    input  logic            take_i,
    output logic [PC_W-1:0] npc_o
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp;

    assign seq_pc = pc_i + PC_W'(1);

    always_comb begin
        case (disp_sel_i)
            DISP_OFF: disp = PC_W'($signed(offset_i));
            DISP_IMM: disp = PC_W'($signed(imm_i));
            default:  disp = '0;
        endcase
    end

    assign npc_o = take_i ? (seq_pc + disp) : seq_pc;

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
    import bnpc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int PC_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [7:0]      opcode_i,
    input  logic [3:0]      src_field_i,
    input  logic [15:0]     offset_i,
    input  logic [31:0]     imm_i,
    input  logic [XLEN-1:0] dst_val_i,
    input  logic [XLEN-1:0] src_val_i,
    input  logic [PC_W-1:0] pc_i,
    output logic            taken_o,
    output logic [PC_W-1:0] next_pc_o,
    output logic            call_o,
    output logic            call_local_o,
    output logic            exit_o,
    output logic            illegal_o
);

    localparam int LANES = 2;

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] npc;
        logic            call;
        logic            call_local;
        logic            exit;
        logic            illegal;
    } res_t;

    dec_t             dec;
    logic [LANES-1:0] hit;
    logic             cond_hit;
    logic             take;
    logic [PC_W-1:0]  npc;
    res_t             res_d, res_q;

    bnpc_decode u_dec (
        .opcode_i    (opcode_i),
        .src_field_i (src_field_i),
        .dec_o       (dec)
    );

    // Lane 0 compares the full width, lane 1 the low half.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = XLEN >> g;
        logic [LW-1:0] rhs;
        assign rhs = dec.use_reg ? src_val_i[LW-1:0] : LW'($signed(imm_i));
        bnpc_compare #(.W(LW)) u_cmp (
            .lhs_i  (dst_val_i[LW-1:0]),
            .rhs_i  (rhs),
            .code_i (dec.code),
            .hit_o  (hit[g])
        );
    end

    assign cond_hit = dec.wide ? hit[0] : hit[1];
    assign take     = dec.uncond || (dec.is_cond && cond_hit);

    bnpc_target #(.PC_W(PC_W)) u_tgt (
        .pc_i       (pc_i),
        .disp_sel_i (dec.disp_sel),
        .offset_i   (offset_i),
        .imm_i      (imm_i),
        .take_i     (take),
        .npc_o      (npc)
    );

    always_comb begin
        res_d            = '0;
        res_d.taken      = take;
        res_d.npc        = npc;
        res_d.call       = dec.call;
        res_d.call_local = dec.call_local;
        res_d.exit       = dec.exit;
        res_d.illegal    = dec.illegal;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign taken_o      = res_q.taken;
    assign next_pc_o    = res_q.npc;
    assign call_o       = res_q.call;
    assign call_local_o = res_q.call_local;
    assign exit_o       = res_q.exit;
    assign illegal_o    = res_q.illegal;

    // R12: an illegal result carries no other effect
    a_r12_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (!taken_o && !call_o && !exit_o));

    // R11: exit is never a taken transfer
    a_r11_exit_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exit_o |-> !taken_o);

    // R10: a local call is always a taken call
    a_r10_local_is_taken_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
        call_local_o |-> (call_o && taken_o));

    // R8: untaken instructions fall through to the next slot
    a_r8_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take |=> (next_pc_o == $past(pc_i) + PC_W'(1)));

    // R13: non-jump classes leave every output quiet
    a_r13_other_class_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i[2:0] != CLS_J64 && opcode_i[2:0] != CLS_J32)
        |=> (!taken_o && !call_o && !exit_o && !illegal_o));

    // R11: exit is never requested from the 32-bit class
    a_r11_no_exit_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i[2:0] == CLS_J32) |=> !exit_o);

    // R12: request flags are mutually exclusive
    a_r12_flags_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({call_o, exit_o, illegal_o}));

endmodule

// File: tb/bnpc_unit_tb.sv
`timescale 1ns/1ps
module bnpc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  sfield = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dval = '0;
    logic [63:0] sval = '0;
    logic [31:0] pc = '0;
    logic        taken, call, call_local, ex, illegal;
    logic [31:0] npc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bnpc_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .src_field_i(sfield),
        .offset_i(offset), .imm_i(imm), .dst_val_i(dval), .src_val_i(sval),
        .pc_i(pc), .taken_o(taken), .next_pc_o(npc), .call_o(call),
        .call_local_o(call_local), .exit_o(ex), .illegal_o(illegal)
    );

    logic [63:0] vals [8];
    initial begin
        vals[0] = 64'h0;
        vals[1] = 64'h1;
        vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h8000_0000_0000_0000;
        vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        vals[5] = 64'h0000_0001_0000_0000;
        vals[6] = 64'h0000_0000_8000_0000;
        vals[7] = 64'h1234_5678_FFFF_FFFE;
    end

    task automatic model(input logic [7:0] op, input logic [3:0] kind,
                         input logic [15:0] off, input logic [31:0] im,
                         input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] p,
                         output logic t, output logic [31:0] np,
                         output logic c, output logic cl,
                         output logic e, output logic il);
        logic [2:0] cls;
        int code;
        logic [63:0] bfull;
        logic [64:0] ua, ub;
        logic signed [64:0] sa, sb;
        logic r;
        logic [31:0] disp;
        cls = op[2:0];
        code = int'(op[7:4]);
        bfull = op[3] ? s : {{32{im[31]}}, im};
        if (cls == 3'd5) begin
            ua = {1'b0, d};            ub = {1'b0, bfull};
            sa = {d[63], d};           sb = {bfull[63], bfull};
        end else begin
            ua = {33'b0, d[31:0]};     ub = {33'b0, bfull[31:0]};
            sa = {{33{d[31]}}, d[31:0]}; sb = {{33{bfull[31]}}, bfull[31:0]};
        end
        case (code)
            1:  r = (ua == ub);
            5:  r = (ua != ub);
            4:  r = ((ua & ub) != 0);
            2:  r = (ua > ub);
            3:  r = (ua >= ub);
            10: r = (ua < ub);
            11: r = (ua <= ub);
            6:  r = (sa > sb);
            7:  r = (sa >= sb);
            12: r = (sa < sb);
            13: r = (sa <= sb);
            default: r = 1'b0;
        endcase
        t = 0; c = 0; cl = 0; e = 0; il = 0;
        disp = {{16{off[15]}}, off};
        if (cls == 3'd5 || cls == 3'd6) begin
            if (code == 0) begin
                t = 1;
                if (cls == 3'd6) disp = im;
            end else if (code == 8) begin
                if (kind == 4'd1) begin c = 1; cl = 1; t = 1; disp = im; end
                else if (kind == 4'd0 || kind == 4'd2) c = 1;
                else il = 1;
            end else if (code == 9) begin
                if (cls == 3'd5) e = 1; else il = 1;
            end else if (code >= 14) begin
                il = 1;
            end else begin
                t = r;
            end
        end
        np = t ? (p + 32'd1 + disp) : (p + 32'd1);
    endtask

    function automatic string tag_of(input logic [7:0] op);
        int code;
        code = int'(op[7:4]);
        if (op[2:0] != 3'd5 && op[2:0] != 3'd6) return "R13";
        case (code)
            0: return "R9";
            1, 4, 5: return "R5 (R3 R4 R8)";
            2, 3, 10, 11: return "R6 (R3 R4 R8)";
            6, 7, 12, 13: return "R7 (R3 R4 R8)";
            8: return "R10";
            9: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic t, input logic [31:0] np,
                       input logic c, input logic cl, input logic e, input logic il);
        checks++;
        if (taken !== t || npc !== np || call !== c || call_local !== cl ||
            ex !== e || illegal !== il) begin
            errors++;
            $display("FAIL %s: actual t=%0b np=%h c=%0b cl=%0b e=%0b il=%0b expected t=%0b np=%h c=%0b cl=%0b e=%0b il=%0b",
                     tag, taken, npc, call, call_local, ex, illegal, t, np, c, cl, e, il);
        end
    endtask

    task automatic run(input string tag, input logic [7:0] op, input logic [3:0] kind,
                       input logic [15:0] off, input logic [31:0] im,
                       input logic [63:0] d, input logic [63:0] s, input logic [31:0] p);
        logic t, c, cl, e, il;
        logic [31:0] np;
        opcode = op; sfield = kind; offset = off; imm = im; dval = d; sval = s; pc = p;
        model(op, kind, off, im, d, s, p, t, np, c, cl, e, il);
        @(negedge clk);
        cmp(tag, t, np, c, cl, e, il);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired (R2)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", 0, 32'h0, 0, 0, 0, 0);
        rst_n = 1'b1;

        // R2: output holds until the next edge
        opcode = 8'h05; offset = 16'd10; pc = 32'd100;
        #1;
        cmp("R2", 0, 32'h0, 0, 0, 0, 0);
        @(negedge clk);
        cmp("R2", 1, 32'd111, 0, 0, 0, 0);

        // Main sweep over both classes, all codes, both sources
        for (int ci = 0; ci < 2; ci++) begin
            for (int code = 0; code < 16; code++) begin
                for (int sb = 0; sb < 2; sb++) begin
                    for (int di = 0; di < 8; di++) begin
                        for (int si = 0; si < 8; si++) begin
                            logic [7:0] op;
                            op = {4'(code), 1'(sb), (ci == 0) ? 3'd5 : 3'd6};
                            run(tag_of(op), op, 4'd0, 16'(di * 9000 - 30000),
                                vals[(si + 3) % 8][31:0] ^ 32'(si << 4),
                                vals[di], vals[si], 32'(di * 1000 + si * 17));
                        end
                    end
                end
            end
        end

        // R3: equal low halves, different upper halves
        run("R3", 8'h1d, 4'd0, 16'd4, 32'd0, 64'h1_0000_0005, 64'h2_0000_0005, 32'd50);
        run("R3", 8'h1e, 4'd0, 16'd4, 32'd0, 64'h1_0000_0005, 64'h2_0000_0005, 32'd50);

        // R4: negative immediate sign-extended to 64 bits
        run("R4", 8'h15, 4'd0, 16'd2, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd7);

        // R8 / R9: wrap-around and displacement sources
        run("R8", 8'h05, 4'd0, 16'h0000, 32'd0, 64'd0, 64'd0, 32'hFFFF_FFFF);
        run("R8", 8'h05, 4'd0, 16'hFFFF, 32'd0, 64'd0, 64'd0, 32'h0);
        run("R9", 8'h06, 4'd0, 16'h0003, 32'h8000_0000, 64'd0, 64'd0, 32'h10);
        run("R9", 8'h06, 4'd0, 16'h0003, 32'h0001_0000, 64'd0, 64'd0, 32'h10);

        // R10: every call-kind value in both classes
        for (int ci = 0; ci < 2; ci++) begin
            for (int k = 0; k < 16; k++) begin
                run("R10", (ci == 0) ? 8'h85 : 8'h86, 4'(k), 16'd9,
                    32'hFFFF_FFF0, 64'd0, 64'd0, 32'h0000_0008);
            end
        end

        // R13: other classes with every code
        for (int cl = 0; cl < 8; cl++) begin
            if (cl == 5 || cl == 6) continue;
            for (int code = 0; code < 16; code++) begin
                run("R13", {4'(code), 1'b1, 3'(cl)}, 4'd1, 16'd5, 32'd5,
                    64'd1, 64'd1, 32'(cl * 31 + code));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule